// File: doc/BRIEF.md
# Tuner Synthesizer I2C Control Slave

This block is the serial control front end of a frequency synthesizer. It listens to an I2C bus through oversampled SDA and SCL lines on a fast system clock and recognises START, STOP and every data bit. It answers to one of four device addresses, chosen by a two-bit select input, and keeps the synthesizer's divider word, control bits and port latches.

There is no register pointer. In a write transfer, the top bit of each data byte decides what the byte is. A byte with that bit clear opens a divider pair, and a byte with that bit set opens a control pair. The byte after the opener always completes the pair. Pairs may follow one another in any order within one transfer.

A read transfer returns a status byte assembled from the lock indication, a power-on flag, three port input levels and a five-level converter code. The status byte repeats for as long as the controller acknowledges it. The power-on flag forces every port output inactive until a read transfer is closed by a STOP.

Top module: `tsyn_i2c_ctrl`

## Requirements
- R1: After reset the divider word, all control bits and the port outputs are 0, the power-on flag is 1 and SDA is released.
- R2: The device acknowledges only the address byte 1,1,0,0,0,AS1,AS2,RW (MSB first), where AS1 is addr_sel[1] and AS2 is addr_sel[0], and RW=0 means write and RW=1 means read. Any other address gets no acknowledge, and the bytes that follow it, up to the next START, change nothing.
- R3: A write data byte with bit 7 clear carries divider bits 14..8 in its bits 6..0, and the next byte carries bits 7..0. div_word changes only after the second byte, with all 15 bits at once.
- R4: A write data byte with bit 7 set takes effect at once. Its bit 6 sets cp_hi, bit 5 sets tst_en, bit 4 sets cp_off, bits 3..1 set ref_sel[2:0] and bit 0 sets drv_off.
- R5: The byte after a control opener sets the port latches. Its bits 7..3 go to port_q[5:1] and its bit 0 goes to port_q[0]. Its bits 2..1 are ignored.
- R6: Divider and control pairs may follow each other in any order within one transfer. Each pair takes effect without a STOP.
- R7: In a read transfer the status byte is {por_flag, lock_i, port_in[2], port_in[1], port_in[0], adc code[2:0]}, sent MSB first. The device changes SDA only while SCL is low.
- R8: When the controller acknowledges a status byte, another status byte follows, sampled afresh. When it does not, the device releases SDA.
- R9: The power-on flag is set by reset or by por_evt_i. It clears when a STOP ends a transfer that included a read. While it is set, port_q is all zero, and the programmed port latches reappear once it clears.
- R10: The adc code is k+1, where k is the highest set bit of adc_cmp[3:0], and 000 when no bit is set. This gives 100, 011, 010, 001 and 000 from the highest band to the lowest.
- R11: A START or a STOP that arrives inside a byte aborts the transfer and discards a half-received pair. The next data byte is then decoded as a pair opener.
- R12: Pulses on SCL or SDA that last two system clocks or less are ignored. They neither clock a bit nor form a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 2 | Address select bits AS1 (bit 1) and AS2 (bit 0) |
| lock_i | input | 1 | Loop lock indication |
| port_in | input | 3 | Port input levels reported in the status byte |
| adc_cmp | input | 4 | Converter comparator outputs, bit k above threshold k |
| por_evt_i | input | 1 | Low-supply event, sets the power-on flag |
| div_word | output | 15 | Programmable divider value |
| cp_hi | output | 1 | Charge-pump high current |
| tst_en | output | 1 | Divider test mode |
| cp_off | output | 1 | Charge-pump disable |
| ref_sel | output | 3 | Reference divider select |
| drv_off | output | 1 | Tuning drive disable |
| port_q | output | 6 | Port outputs, 1 = active |
| por_flag | output | 1 | Power-on flag |

## Verification
Pair decoding is driven with divider pairs, control pairs and mixed sequences in a single transfer. These runs separate a correct pair tracker from one that decodes each byte by its top bit, and from one that commits the divider word after its first byte. Transfers broken off inside a byte by a START or a STOP show whether a stale pair half survives, because the next byte lands as the wrong kind. Multi-byte reads with a different comparator pattern behind each byte, one of them not thermometer-shaped, separate per-byte sampling and the highest-bit encoding from a plain count of set bits. Short glitches on both lines while a divider byte is shifted in separate a working filter from a bare synchronizer.

// File: rtl/tsyn_pkg.sv
package tsyn_pkg;

  localparam int BYTE_W  = 8;
  localparam int PORT_W  = 6;
  localparam int CTL_W   = 7;
  localparam logic [4:0] ADDR_HEAD = 5'b11000;

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_ADDR,
    BS_AACK,
    BS_WBYTE,
    BS_WACK,
    BS_RBYTE,
    BS_RACK
  } bus_state_e;

  typedef enum logic [1:0] {
    PR_NONE,
    PR_DIV,
    PR_CTL
  } pair_e;

  typedef struct packed {
    logic       cp_hi;
    logic       tst_en;
    logic       cp_off;
    logic [2:0] ref_sel;
    logic       drv_off;
  } ctl_t;

  function automatic logic [2:0] adc_code(input logic [3:0] cmp);
    logic [2:0] code;
    code = 3'd0;
    for (int k = 0; k < 4; k++) begin
      if (cmp[k]) code = 3'(k + 1);
    end
    return code;
  endfunction

endpackage

// File: rtl/tsyn_line_filter.sv
module tsyn_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [FILT_LEN-1:0]    hist_q, hist_d;
  logic                   out_q, out_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
    hist_d = {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
    out_d  = out_q;
    if (&hist_q)       out_d = 1'b1;
    else if (~|hist_q) out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
      out_q  <= out_d;
    end
  end

  assign line_o = out_q;

endmodule

// File: rtl/tsyn_bus_engine.sv
module tsyn_bus_engine
  import tsyn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] status,
  output logic              sda_oe,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_dat,
  output logic              seq_abort,
  output logic              por_clr
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  bus_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic              rd_q, rd_d;
  logic              mack_q, mack_d;
  logic              scl_q, sda_q;

  logic start_c, stop_c, rise_c, fall_c;

  assign start_c = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c  = scl_f & scl_q & ~sda_q & sda_f;
  assign rise_c  = scl_f & ~scl_q;
  assign fall_c  = ~scl_f & scl_q;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    oe_d      = oe_q;
    rd_d      = rd_q;
    mack_d    = mack_q;
    byte_stb  = 1'b0;
    seq_abort = 1'b0;
    por_clr   = 1'b0;
    if (start_c) begin
      st_d      = BS_ADDR;
      cnt_d     = '0;
      oe_d      = 1'b0;
      seq_abort = 1'b1;
    end else if (stop_c) begin
      st_d      = BS_IDLE;
      oe_d      = 1'b0;
      seq_abort = 1'b1;
      por_clr   = rd_q;
      rd_d      = 1'b0;
    end else begin
      unique case (st_q)
        BS_ADDR, BS_WBYTE: begin
          if (rise_c && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_f};
            cnt_d = cnt_q + 1'b1;
          end else if (fall_c && cnt_q == CNT_FULL) begin
            if (st_q == BS_WBYTE) begin
              byte_stb = 1'b1;
              oe_d     = 1'b1;
              st_d     = BS_WACK;
            end else if (sh_q[BYTE_W-1:1] == dev_addr) begin
              oe_d = 1'b1;
              st_d = BS_AACK;
            end else begin
              st_d = BS_IDLE;
            end
          end
        end
        BS_AACK: begin
          if (fall_c) begin
            cnt_d = '0;
            if (sh_q[0]) begin
              st_d = BS_RBYTE;
              sh_d = status;
              oe_d = ~status[BYTE_W-1];
              rd_d = 1'b1;
            end else begin
              st_d = BS_WBYTE;
              oe_d = 1'b0;
            end
          end
        end
        BS_WACK: begin
          if (fall_c) begin
            oe_d  = 1'b0;
            cnt_d = '0;
            st_d  = BS_WBYTE;
          end
        end
        BS_RBYTE: begin
          if (fall_c) begin
            if (cnt_q == CNT_LAST) begin
              oe_d = 1'b0;
              st_d = BS_RACK;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~sh_q[BYTE_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        BS_RACK: begin
          if (rise_c) begin
            mack_d = ~sda_f;
          end else if (fall_c) begin
            if (mack_q) begin
              st_d  = BS_RBYTE;
              sh_d  = status;
              oe_d  = ~status[BYTE_W-1];
              cnt_d = '0;
            end else begin
              st_d = BS_IDLE;
              oe_d = 1'b0;
            end
          end
        end
        default: begin
          st_d = st_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BS_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      oe_q   <= 1'b0;
      rd_q   <= 1'b0;
      mack_q <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      oe_q   <= oe_d;
      rd_q   <= rd_d;
      mack_q <= mack_d;
      scl_q  <= scl_f;
      sda_q  <= sda_f;
    end
  end

  assign sda_oe   = oe_q;
  assign byte_dat = sh_q;

endmodule

// File: rtl/tsyn_reg_bank.sv
module tsyn_reg_bank
  import tsyn_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic [BYTE_W-1:0] byte_dat,
  input  logic              seq_abort,
  input  logic              por_clr,
  input  logic              por_evt,
  output logic [DIV_W-1:0]  div_word,
  output ctl_t              ctl,
  output logic [PORT_W-1:0] port_lat,
  output logic              por_flag
);

  localparam int HI_W = DIV_W - BYTE_W;

  pair_e             pr_q, pr_d;
  logic [HI_W-1:0]   hold_q;
  logic [DIV_W-1:0]  div_q;
  ctl_t              ctl_q;
  logic [PORT_W-1:0] port_q;
  logic              por_q, por_d;
  logic              hold_en, div_en, ctl_en, port_en;

  always_comb begin
    pr_d    = pr_q;
    hold_en = 1'b0;
    div_en  = 1'b0;
    ctl_en  = 1'b0;
    port_en = 1'b0;
    if (seq_abort) begin
      pr_d = PR_NONE;
    end else if (byte_stb) begin
      unique case (pr_q)
        PR_DIV: begin
          div_en = 1'b1;
          pr_d   = PR_NONE;
        end
        PR_CTL: begin
          port_en = 1'b1;
          pr_d    = PR_NONE;
        end
        default: begin
          if (byte_dat[BYTE_W-1]) begin
            ctl_en = 1'b1;
            pr_d   = PR_CTL;
          end else begin
            hold_en = 1'b1;
            pr_d    = PR_DIV;
          end
        end
      endcase
    end
    por_d = por_q;
    if (por_evt)      por_d = 1'b1;
    else if (por_clr) por_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_q   <= PR_NONE;
      hold_q <= '0;
      div_q  <= '0;
      ctl_q  <= '0;
      port_q <= '0;
      por_q  <= 1'b1;
    end else begin
      pr_q  <= pr_d;
      por_q <= por_d;
      if (hold_en) hold_q <= byte_dat[HI_W-1:0];
      if (div_en)  div_q  <= {hold_q, byte_dat};
      if (ctl_en)  ctl_q  <= ctl_t'(byte_dat[CTL_W-1:0]);
      if (port_en) port_q <= {byte_dat[BYTE_W-1:3], byte_dat[0]};
    end
  end

  assign div_word = div_q;
  assign ctl      = ctl_q;
  assign port_lat = port_q;
  assign por_flag = por_q;

endmodule

// File: rtl/tsyn_i2c_ctrl.sv
module tsyn_i2c_ctrl
  import tsyn_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int DIV_W       = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        addr_sel,
  input  logic              lock_i,
  input  logic [2:0]        port_in,
  input  logic [3:0]        adc_cmp,
  input  logic              por_evt_i,
  output logic [DIV_W-1:0]  div_word,
  output logic              cp_hi,
  output logic              tst_en,
  output logic              cp_off,
  output logic [2:0]        ref_sel,
  output logic              drv_off,
  output logic [PORT_W-1:0] port_q,
  output logic              por_flag
);

  localparam int LINES = 2;

  logic [LINES-1:0]  raw_l, filt_l;
  logic              scl_f, sda_f;
  logic [6:0]        dev_addr;
  logic [BYTE_W-1:0] status;
  logic              byte_stb, seq_abort, por_clr;
  logic [BYTE_W-1:0] byte_dat;
  ctl_t              ctl;
  logic [PORT_W-1:0] port_lat;

  assign raw_l = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    tsyn_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(raw_l[g]),
      .line_o(filt_l[g])
    );
  end

  assign scl_f    = filt_l[1];
  assign sda_f    = filt_l[0];
  assign dev_addr = {ADDR_HEAD, addr_sel};
  assign status   = {por_flag, lock_i, port_in, adc_code(adc_cmp)};

  tsyn_bus_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .dev_addr (dev_addr),
    .status   (status),
    .sda_oe   (sda_oe),
    .byte_stb (byte_stb),
    .byte_dat (byte_dat),
    .seq_abort(seq_abort),
    .por_clr  (por_clr)
  );

  tsyn_reg_bank #(
    .DIV_W(DIV_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_stb (byte_stb),
    .byte_dat (byte_dat),
    .seq_abort(seq_abort),
    .por_clr  (por_clr),
    .por_evt  (por_evt_i),
    .div_word (div_word),
    .ctl      (ctl),
    .port_lat (port_lat),
    .por_flag (por_flag)
  );

  assign cp_hi   = ctl.cp_hi;
  assign tst_en  = ctl.tst_en;
  assign cp_off  = ctl.cp_off;
  assign ref_sel = ctl.ref_sel;
  assign drv_off = ctl.drv_off;
  assign port_q  = por_flag ? '0 : port_lat;

endmodule

// File: rtl/tsyn_i2c_chk.sv
module tsyn_i2c_chk #(
  parameter int DIV_W  = 15,
  parameter int PORT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              sda_oe,
  input logic              por_evt_i,
  input logic              por_flag,
  input logic              por_clr,
  input logic              byte_stb,
  input logic [DIV_W-1:0]  div_word,
  input logic [PORT_W-1:0] port_q
);

  // R9: a low-supply event raises the flag on the next cycle
  a_r9_por_set: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt_i |=> por_flag);

  // R9: a STOP after a read clears the flag unless an event competes
  a_r9_por_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (por_clr && !por_evt_i) |=> !por_flag);

  // R3: the divider word moves only right after a delivered byte
  a_r3_div_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (div_word != $past(div_word)) |-> $past(byte_stb));

  // R5: ports move only after a delivered byte or a flag change
  a_r5_port_source: assert property (@(posedge clk) disable iff (!rst_n)
    (port_q != $past(port_q)) |-> ($past(byte_stb) || (por_flag != $past(por_flag))));

  // R7: the device never starts pulling SDA while SCL stays high
  a_r7_no_pull_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f) && !$past(sda_oe)) |-> !sda_oe);

endmodule

bind tsyn_i2c_ctrl tsyn_i2c_chk #(
  .DIV_W (DIV_W),
  .PORT_W(tsyn_pkg::PORT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_f),
  .sda_oe   (sda_oe),
  .por_evt_i(por_evt_i),
  .por_flag (por_flag),
  .por_clr  (por_clr),
  .byte_stb (byte_stb),
  .div_word (div_word),
  .port_q   (port_q)
);

// File: tb/tsyn_i2c_ctrl_tb.sv
module tsyn_i2c_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_oe;
  logic [1:0]  addr_sel = 2'b00;
  logic        lock_i = 1'b0;
  logic [2:0]  port_in = 3'b000;
  logic [3:0]  adc_cmp = 4'b0000;
  logic        por_evt_i = 1'b0;
  logic [14:0] div_word;
  logic        cp_hi, tst_en, cp_off, drv_off, por_flag;
  logic [2:0]  ref_sel;
  logic [5:0]  port_q;
  wire         sda_line = sda_m & ~sda_oe;

  tsyn_i2c_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .lock_i(lock_i), .port_in(port_in), .adc_cmp(adc_cmp),
    .por_evt_i(por_evt_i), .div_word(div_word), .cp_hi(cp_hi), .tst_en(tst_en),
    .cp_off(cp_off), .ref_sel(ref_sel), .drv_off(drv_off), .port_q(port_q),
    .por_flag(por_flag)
  );

  int n_chk = 0, n_fail = 0;
  bit mon_en = 0, rd_flag = 0, ack;
  logic [14:0] m_div = '0;
  logic [6:0]  m_ctl = '0, m_hold = '0;
  logic [5:0]  m_ports = '0;
  bit          m_por = 1;
  int          pend = 0;
  logic [7:0]  v;
  int          adc_q[$];

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [2:0] exp_code(input logic [3:0] c);
    if (c[3]) return 3'b100;
    if (c[2]) return 3'b011;
    if (c[1]) return 3'b010;
    if (c[0]) return 3'b001;
    return 3'b000;
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_por, lock_i, port_in, exp_code(adc_cmp)};
  endfunction

  function automatic logic [5:0] exp_ports();
    return m_por ? 6'd0 : m_ports;
  endfunction

  always @(negedge clk) begin
    if (mon_en) begin
      chk("R3 monitor div", div_word, m_div);
      chk("R4 monitor ctl", {cp_hi, tst_en, cp_off, ref_sel, drv_off}, m_ctl);
      chk("R9 monitor ports", port_q, exp_ports());
      chk("R9 monitor flag", por_flag, m_por);
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_byte(input logic [7:0] b);
    case (pend)
      1: begin m_div = {m_hold, b}; pend = 0; end
      2: begin m_ports = {b[7:3], b[0]}; pend = 0; end
      default: begin
        if (!b[7]) begin m_hold = b[6:0]; pend = 1; end
        else begin m_ctl = b[6:0]; pend = 2; end
      end
    endcase
  endtask

  task automatic bus_start();
    mon_en = 0;
    sda_m = 1; wt(Q); scl_m = 1; wt(Q); sda_m = 0; wt(Q); scl_m = 0; wt(4);
    pend = 0;
  endtask

  task automatic bus_stop();
    mon_en = 0;
    sda_m = 0; wt(Q); scl_m = 1; wt(Q); sda_m = 1; wt(Q);
    pend = 0;
    if (rd_flag) m_por = 0;
    rd_flag = 0;
    mon_en = 1;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(Q); scl_m = 1; wt(Q); scl_m = 0; wt(4);
  endtask

  task automatic get_ack(output bit a);
    sda_m = 1; wt(Q); scl_m = 1; wt(Q / 2); a = !sda_line; wt(Q / 2); scl_m = 0; wt(4);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit a);
    mon_en = 0;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    get_ack(a);
  endtask

  task automatic wr_data(input logic [7:0] b, input string tag);
    bit a;
    wr_byte(b, a);
    chk(tag, a, 1);
    if (a) model_byte(b);
    mon_en = 1;
  endtask

  task automatic rd_byte(output logic [7:0] r);
    logic [7:0] late;
    mon_en = 0;
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_m = 1; wt(Q / 2); r[i] = sda_line;
      wt(Q / 2 - 1); late[i] = sda_line; wt(1); scl_m = 0; wt(4);
    end
    chk("R7 data held while SCL high", late, r);
  endtask

  task automatic master_ack(input bit a);
    sda_m = !a; wt(Q); scl_m = 1; wt(Q); scl_m = 0; wt(4); sda_m = 1;
  endtask

  task automatic glitch_byte(input logic [7:0] b, output bit a);
    mon_en = 0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q / 2);
      scl_m = 1; wt(2); scl_m = 0;
      wt(Q / 2 - 2); scl_m = 1; wt(Q / 2);
      sda_m = !b[i]; wt(2); sda_m = b[i];
      wt(Q / 2 - 2); scl_m = 0; wt(4);
    end
    get_ack(a);
  endtask

  initial begin
    wt(CLK_PERIOD * 0 + 200000);
    chk("watchdog expired", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wt(5);
    rst_n = 1;
    wt(2);
    // R1 reset state
    chk("R1 div", div_word, 0);
    chk("R1 ctl", {cp_hi, tst_en, cp_off, ref_sel, drv_off}, 0);
    chk("R1 ports", port_q, 0);
    chk("R1 flag", por_flag, 1);
    chk("R1 sda released", sda_oe, 0);
    mon_en = 1;

    // R9: ports held inactive while the flag is set
    bus_start(); wr_byte(8'hC0, ack); chk("R2 ack C0", ack, 1);
    wr_data(8'hFF, "R4 ack"); wr_data(8'hF9, "R5 ack");
    chk("R9 ports forced", port_q, 0);
    bus_stop();

    // R7/R8/R9: read, nack, stop clears flag
    lock_i = 1; port_in = 3'b101; adc_cmp = 4'b0011;
    bus_start(); wr_byte(8'hC1, ack); chk("R2 ack read", ack, 1); rd_flag = 1;
    rd_byte(v); chk("R7 status", v, exp_status());
    master_ack(0); wt(Q);
    chk("R8 release after nack", sda_line, 1);
    bus_stop();
    chk("R9 flag cleared", por_flag, 0);
    chk("R9 ports restored", port_q, 6'h3F);

    // R2: wrong address ignored
    bus_start(); wr_byte(8'hC2, ack); chk("R2 no ack C2", ack, 0);
    wr_byte(8'h12, ack); wr_byte(8'h34, ack); chk("R2 bytes ignored ack", ack, 0);
    bus_stop();
    chk("R2 div untouched", div_word, 0);
    addr_sel = 2'b01;
    bus_start(); wr_byte(8'hC2, ack); chk("R2 ack with AS2", ack, 1);
    mon_en = 1;

    // R3 divider pair
    wr_data(8'h3A, "R3 ack");
    chk("R3 div waits for pair", div_word, 0);
    wr_data(8'h5C, "R3 ack");
    chk("R3 div committed", div_word, 15'h3A5C);

    // R4/R5 control pair
    wr_data(8'hDA, "R4 ack");
    chk("R4 ctl fields", {cp_hi, tst_en, cp_off, ref_sel, drv_off}, 7'h5A);
    wr_data(8'hA5, "R5 ack");
    chk("R5 ports", port_q, 6'b101001);
    wr_data(8'h86, "R4 ack");
    wr_data(8'h06, "R5 ack");
    chk("R5 bits 2..1 ignored", port_q, 0);

    // R6 mixed pairs then repeated start, no stop
    bus_start(); wr_byte(8'hC2, ack); chk("R6 readdress", ack, 1);
    wr_data(8'hC3, "R6 ack"); wr_data(8'h5A, "R6 ack");
    wr_data(8'h7F, "R6 ack"); wr_data(8'hFF, "R6 ack");
    bus_start(); mon_en = 1;
    chk("R6 div", div_word, 15'h7FFF);
    chk("R6 ctl", {cp_hi, tst_en, cp_off, ref_sel, drv_off}, 7'h43);
    chk("R6 ports", port_q, 6'h16);
    bus_stop();

    // R10/R8 multi-byte read with changing comparator inputs
    lock_i = 0; port_in = 3'b010;
    adc_q = '{4'b0000, 4'b0001, 4'b0111, 4'b1111, 4'b0100};
    adc_cmp = 4'(adc_q[0]);
    bus_start(); wr_byte(8'hC3, ack); chk("R8 read ack", ack, 1); rd_flag = 1;
    for (int k = 0; k < 5; k++) begin
      rd_byte(v);
      chk("R10 adc code", v, exp_status());
      if (k < 4) adc_cmp = 4'(adc_q[k + 1]);
      master_ack(k < 4);
    end
    bus_stop();

    // R11 abort by START and by STOP inside a byte
    bus_start(); wr_byte(8'hC2, ack); mon_en = 1;
    wr_data(8'h12, "R11 ack");
    mon_en = 0;
    for (int i = 7; i >= 4; i--) send_bit(1'(8'h34 >> i));
    bus_start(); wr_byte(8'hC2, ack); mon_en = 1;
    wr_data(8'h80, "R11 ack");
    chk("R11 div kept after START abort", div_word, 15'h7FFF);
    chk("R11 opener decoded as control", {cp_hi, tst_en, cp_off, ref_sel, drv_off}, 0);
    bus_start(); wr_byte(8'hC2, ack); mon_en = 1;
    wr_data(8'h11, "R11 ack");
    mon_en = 0;
    for (int i = 7; i >= 5; i--) send_bit(1'(8'h55 >> i));
    bus_stop();
    bus_start(); wr_byte(8'hC2, ack); mon_en = 1;
    wr_data(8'h22, "R11 ack");
    chk("R11 no stale half after STOP", div_word, 15'h7FFF);
    wr_data(8'h33, "R11 ack");
    chk("R11 fresh pair", div_word, 15'h2233);
    bus_stop();

    // R12 glitches on both lines
    bus_start(); wr_byte(8'hC2, ack);
    glitch_byte(8'h11, ack); chk("R12 glitched byte ack", ack, 1);
    model_byte(8'h11); mon_en = 1;
    wr_data(8'h44, "R12 ack");
    chk("R12 div through glitches", div_word, 15'h1144);
    bus_stop();

    // R9 low-supply event
    mon_en = 0;
    por_evt_i = 1; wt(1); por_evt_i = 0; m_por = 1; wt(1);
    mon_en = 1;
    chk("R9 event sets flag", por_flag, 1);
    chk("R9 event forces ports", port_q, 0);
    bus_start(); wr_byte(8'hC3, ack); rd_flag = 1;
    rd_byte(v); chk("R9 flag in status", v[7], 1);
    master_ack(0); bus_stop();
    chk("R9 latches survive", port_q, m_ports);

    mon_en = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule